// File: doc/BRIEF.md
# Multi-Width Host Register Interface

This block is the slave side of a simple asynchronous microcontroller bus. It has an active-low chip select, separate active-low read and write strobes, an 8-bit byte address and a 32-bit data path. The data path is split into input, output and output-enable so that the pad ring can build the tri-state driver. Two strap inputs choose the bus width: 8, 16 or 32 bits. The block steers byte lanes so that the 32-bit internal registers can be reached through any of the three widths.

The block holds the registers that a mixing datapath reads. These are a control byte with a self-clearing soft-reset bit, a pattern-match configuration word, a delay configuration word and a bank of thirty-two 24-bit coefficients. Two 32-bit status words supplied by the datapath can be read back through the bus. A write is taken in when the write strobe is released. The strobes are brought into the local clock domain through a short synchroniser. Reads are combinational from the address pins and are driven only while chip select and the read strobe are both low.

When the soft-reset bit is written to 0, the block requests a datapath resynchronisation and clears the coefficient bank at once. The configuration words keep their values. The bit reads back as 0 until the datapath reports that the resynchronisation has finished, and then it returns to 1.

Top module: `host_regif`

## Requirements
- R1: The width strap decodes as follows: 00 selects an 8-bit bus, 01 a 16-bit bus, and 10 or 11 a 32-bit bus. In 32-bit mode a transfer carries the whole word on data[31:0], and address bits [1:0] have no effect.
- R2: In 16-bit mode the halfword travels on data[15:0]. Address bit 1 picks bits [15:0] (value 0) or bits [31:16] (value 1), and address bit 0 has no effect. Read pins [31:16] return 0.
- R3: In 8-bit mode the byte travels on data[7:0]. Address bits [1:0] pick byte n, which is bits [8n+7:8n]. Read pins [31:8] return 0.
- R4: A 16-bit or 8-bit write changes only the selected lanes of the target register. All other bits of that register keep their values.
- R5: A write takes effect only if chip select is low while the write strobe is low, and it is committed after the write strobe rises. data_oe is 1 only while chip select and the read strobe are both low. Otherwise data_oe is 0 and data_out is 0.
- R6: The control register at 00h resets to 8Bh, and bits [7:1] are writable. Writing 0 to bit 0 raises resync_req, and bit 0 then reads 0. When resync_done is seen, resync_req drops and bit 0 reads 1. Writing 1 to bit 0 has no effect.
- R7: The coefficient registers sit at 80h+4i for i = 0..31. They are 24 bits wide, read back zero-extended and reset to 0. A soft-reset request clears all of them, while the words at 08h and 10h keep their values.
- R8: The word at 08h resets to 076543h and stores only bits [19:0]. The word at 10h resets to 152B6Bh and stores only bits [20:16], [14:8] and [6:0]. All other bits read 0.
- R9: Word 04h returns switch_status and word 0Ch returns match_status. Writes to either word have no effect.
- R10: Reads of any other address below 80h return 0, and writes to those addresses have no effect.
- R11: ctrl_cfg, match_cfg and delay_cfg always show the stored register values. coef_flat[24i+23:24i] shows coefficient i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_width_sel | input | 2 | Bus width strap |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Byte address |
| data_in | input | 32 | Write data from the pads |
| data_out | output | 32 | Read data to the pads |
| data_oe | output | 1 | Pad output enable |
| switch_status | input | 32 | Switching status, eight 4-bit channels |
| match_status | input | 32 | Matching status, eight 4-bit channels |
| resync_done | input | 1 | Datapath reports that resynchronisation is complete |
| resync_req | output | 1 | Soft-reset request pending |
| ctrl_cfg | output | 8 | Control register contents |
| match_cfg | output | 24 | Pattern-match configuration |
| delay_cfg | output | 24 | Delay configuration |
| coef_flat | output | 768 | Coefficient bank, packed with index 0 lowest |

## Verification
A wrong lane decision shows up at once. The next readback of the written register returns the byte or halfword in the wrong position, or shows that neighbouring lanes have been overwritten. A stuck or lost soft-reset state is visible on resync_req and on bit 0 of the control word within a few clocks of the commit or of resync_done. Coefficients that are not cleared show up on the next coefficient read and on coef_flat. The bench runs seeded random transfers across all three widths against an independent register model, and adds directed cases for reset values, reserved bits, read-only words, ignored strobes and the soft-reset sequence.

// File: rtl/host_regif_pkg.sv
// Package: shared types and constants for the host register interface.
// Assumes a fixed 32-bit internal word and byte-granular addressing.
package host_regif_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;

    typedef enum logic [1:0] {
        BW_8  = 2'b00,
        BW_16 = 2'b01,
        BW_32 = 2'b10
    } bus_width_e;

    // word indices (address divided by four) of the low register page
    localparam int WIDX_CTRL   = 0;
    localparam int WIDX_SWST   = 1;
    localparam int WIDX_MATCH  = 2;
    localparam int WIDX_MTST   = 3;
    localparam int WIDX_DELAY  = 4;

    localparam logic [7:0]  CTRL_RST   = 8'h8B;
    localparam logic [23:0] MATCH_RST  = 24'h076543;
    localparam logic [23:0] MATCH_MASK = 24'h0FFFFF;
    localparam logic [23:0] DELAY_RST  = 24'h152B6B;
    localparam logic [23:0] DELAY_MASK = 24'h1F7F7F;

    // strap decode: bit 1 set means full width
    function automatic bus_width_e decode_width(input logic [1:0] strap);
        if (strap[1])      return BW_32;
        else if (strap[0]) return BW_16;
        else               return BW_8;
    endfunction

    // byte-enable merge of a new word into an old one
    function automatic logic [WORD_W-1:0] merge_lanes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int b = 0; b < LANES; b++) begin
            if (be[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/hr_strobe_sync.sv
// Module: hr_strobe_sync
// Brings the asynchronous chip select and write strobe into the clk
// domain. It captures address and data while a qualified write is
// active, and it emits a one-cycle commit pulse when the strobe is released.
// Assumes: address and data stay stable from the strobe falling until
// SYNC_STAGES+1 clocks after it rises, and the strobe lasts at
// least SYNC_STAGES+1 clocks.
module hr_strobe_sync #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic [SYNC_STAGES-1:0] cs_chain;
    logic [SYNC_STAGES-1:0] wr_chain;
    logic                   cs_s;
    logic                   wr_s;
    logic                   wr_prev;
    logic                   armed;

    // shift the strobes through the synchroniser chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_chain <= '1;
            wr_chain <= '1;
        end else begin
            cs_chain <= {cs_chain[SYNC_STAGES-2:0], cs_n};
            wr_chain <= {wr_chain[SYNC_STAGES-2:0], wr_n};
        end
    end

    assign cs_s = cs_chain[SYNC_STAGES-1];
    assign wr_s = wr_chain[SYNC_STAGES-1];

    // arm on a selected write and capture the transfer while it is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev  <= 1'b1;
            armed    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            wr_prev <= wr_s;
            if (!wr_s && !cs_s) begin
                armed    <= 1'b1;
                cap_addr <= addr;
                cap_data <= wdata;
            end else if (wr_commit) begin
                armed <= 1'b0;
            end
        end
    end

    assign wr_commit = armed && wr_s && !wr_prev;

    // R5: a commit never lasts longer than one clock
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

// File: rtl/hr_lane_steer.sv
// Module: hr_lane_steer
// Maps pad lanes to internal word lanes for the selected bus width, in
// both directions. Purely combinational.
// Assumes the width strap is static during a transfer.
module hr_lane_steer
    import host_regif_pkg::*;
(
    input  logic [1:0]        bw_sel,
    input  logic [1:0]        wr_lo,
    input  logic [WORD_W-1:0] pin_wdata,
    input  logic [1:0]        rd_lo,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] wr_word,
    output logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] rd_pins
);

    bus_width_e  bw;
    logic [7:0]  rd_byte [LANES];

    assign bw = decode_width(bw_sel);

    // split the read word into byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_byte[g] = rd_word[g*8 +: 8];
    end

    // write direction: replicate the narrow lane and pick byte enables
    always_comb begin
        case (bw)
            BW_32: begin
                wr_word = pin_wdata;
                wr_be   = '1;
            end
            BW_16: begin
                wr_word = {2{pin_wdata[15:0]}};
                wr_be   = wr_lo[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                wr_word = {LANES{pin_wdata[7:0]}};
                wr_be   = 4'b0001 << wr_lo;
            end
        endcase
    end

    // read direction: bring the selected lane down to the low pins
    always_comb begin
        case (bw)
            BW_32:   rd_pins = rd_word;
            BW_16:   rd_pins = {16'h0, rd_lo[1] ? rd_word[31:16] : rd_word[15:0]};
            default: rd_pins = {24'h0, rd_byte[rd_lo]};
        endcase
    end

endmodule

// File: rtl/hr_reg_bank.sv
// Module: hr_reg_bank
// Holds the control, configuration and coefficient registers. It applies
// byte-enabled writes, runs the soft-reset handshake and decodes reads.
// Assumes: wr_en is a single-cycle pulse and the read index is stable
// while it is sampled.
module hr_reg_bank
    import host_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int COEF_W = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-3:0]                 wr_widx,
    input  logic [WORD_W-1:0]                 wr_word,
    input  logic [LANES-1:0]                  wr_be,
    input  logic [ADDR_W-3:0]                 rd_widx,
    input  logic [WORD_W-1:0]                 sw_status,
    input  logic [WORD_W-1:0]                 mt_status,
    input  logic                              resync_done,
    output logic [WORD_W-1:0]                 rd_word,
    output logic [7:0]                        ctrl_q,
    output logic [23:0]                       match_q,
    output logic [23:0]                       delay_q,
    output logic [(1<<(ADDR_W-3))*COEF_W-1:0] coef_flat,
    output logic                              resync_req
);

    localparam int WIDX_W     = ADDR_W - 2;
    localparam int COEF_IDX_W = ADDR_W - 3;
    localparam int NUM_COEF   = 1 << COEF_IDX_W;

    logic [6:0]            ctrl_hi;
    logic                  pend;
    logic [COEF_W-1:0]     coef_q [NUM_COEF];
    logic                  wr_coef_sel;
    logic [COEF_IDX_W-1:0] wr_cidx;
    logic                  rd_coef_sel;
    logic [COEF_IDX_W-1:0] rd_cidx;
    logic                  soft_start;
    logic                  wr_low_ctrl;
    logic                  wr_low_match;
    logic                  wr_low_delay;
    logic [WORD_W-1:0]     coef_merged;
    logic [WORD_W-1:0]     match_merged;
    logic [WORD_W-1:0]     delay_merged;
    logic                  unused_hi_bits;

    assign wr_coef_sel = wr_widx[WIDX_W-1];
    assign wr_cidx     = wr_widx[COEF_IDX_W-1:0];
    assign rd_coef_sel = rd_widx[WIDX_W-1];
    assign rd_cidx     = rd_widx[COEF_IDX_W-1:0];

    assign wr_low_ctrl  = wr_en && !wr_coef_sel && (wr_widx == WIDX_W'(WIDX_CTRL));
    assign wr_low_match = wr_en && !wr_coef_sel && (wr_widx == WIDX_W'(WIDX_MATCH));
    assign wr_low_delay = wr_en && !wr_coef_sel && (wr_widx == WIDX_W'(WIDX_DELAY));
    assign soft_start   = wr_low_ctrl && wr_be[0] && !wr_word[0];

    // merge the byte-enabled write into each writable target
    assign coef_merged  = merge_lanes({{(WORD_W-COEF_W){1'b0}}, coef_q[wr_cidx]}, wr_word, wr_be);
    assign match_merged = merge_lanes({8'h0, match_q}, wr_word, wr_be);
    assign delay_merged = merge_lanes({8'h0, delay_q}, wr_word, wr_be);
    assign unused_hi_bits = ^{coef_merged[WORD_W-1:COEF_W], match_merged[31:24], delay_merged[31:24]};

    // control bits and the soft-reset pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_hi <= CTRL_RST[7:1];
            pend    <= 1'b0;
        end else begin
            if (wr_low_ctrl && wr_be[0]) ctrl_hi <= wr_word[7:1];
            if (soft_start)              pend <= 1'b1;
            else if (resync_done)        pend <= 1'b0;
        end
    end

    assign ctrl_q     = {ctrl_hi, ~pend};
    assign resync_req = pend;

    // configuration words that survive a soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= MATCH_RST;
            delay_q <= DELAY_RST;
        end else begin
            if (wr_low_match) match_q <= match_merged[23:0] & MATCH_MASK;
            if (wr_low_delay) delay_q <= delay_merged[23:0] & DELAY_MASK;
        end
    end

    // coefficient bank, cleared by hard or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_start) begin
            for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= '0;
        end else if (wr_en && wr_coef_sel) begin
            coef_q[wr_cidx] <= coef_merged[COEF_W-1:0];
        end
    end

    // present the bank to the datapath, index 0 in the low bits
    for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef_out
        assign coef_flat[g*COEF_W +: COEF_W] = coef_q[g];
    end

    // read decode; unmapped words return zero
    always_comb begin
        rd_word = '0;
        if (rd_coef_sel) begin
            rd_word = {{(WORD_W-COEF_W){1'b0}}, coef_q[rd_cidx]};
        end else begin
            case (rd_widx)
                WIDX_W'(WIDX_CTRL):  rd_word = {24'h0, ctrl_q};
                WIDX_W'(WIDX_SWST):  rd_word = sw_status;
                WIDX_W'(WIDX_MATCH): rd_word = {8'h0, match_q};
                WIDX_W'(WIDX_MTST):  rd_word = mt_status;
                WIDX_W'(WIDX_DELAY): rd_word = {8'h0, delay_q};
                default:             rd_word = '0;
            endcase
        end
    end

    // R6: completion clears the request unless a new request arrives
    p_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req && resync_done && !soft_start) |=> !resync_req);

    // R6: the request holds until completion
    p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req && !resync_done) |=> resync_req);

    // R7: a soft reset leaves the bank empty
    p_coef_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start |=> (coef_flat == '0));

    // R7: configuration words survive a soft reset
    p_cfg_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start |=> ($stable(match_q) && $stable(delay_q)));

endmodule

// File: rtl/host_regif.sv
// Module: host_regif (top)
// Microcontroller slave with strap-selected 8/16/32-bit data bus,
// byte-addressed 32-bit registers and a soft-reset handshake.
// Assumes the pad ring builds the tri-state driver from data_out/data_oe.
module host_regif
    import host_regif_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int COEF_W      = 24,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_COEF   = 1 << (ADDR_W - 3)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 bus_width_sel,
    input  logic                       cs_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                data_in,
    output logic [31:0]                data_out,
    output logic                       data_oe,
    input  logic [31:0]                switch_status,
    input  logic [31:0]                match_status,
    input  logic                       resync_done,
    output logic                       resync_req,
    output logic [7:0]                 ctrl_cfg,
    output logic [23:0]                match_cfg,
    output logic [23:0]                delay_cfg,
    output logic [NUM_COEF*COEF_W-1:0] coef_flat
);

    logic              wr_commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [31:0]       cap_data;
    logic [31:0]       wr_word;
    logic [3:0]        wr_be;
    logic [31:0]       rd_word;
    logic [31:0]       rd_pins;
    bus_width_e        bw;

    assign bw = decode_width(bus_width_sel);

    hr_strobe_sync #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (WORD_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .wdata     (data_in),
        .wr_commit (wr_commit),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    hr_lane_steer u_steer (
        .bw_sel    (bus_width_sel),
        .wr_lo     (cap_addr[1:0]),
        .pin_wdata (cap_data),
        .rd_lo     (addr[1:0]),
        .rd_word   (rd_word),
        .wr_word   (wr_word),
        .wr_be     (wr_be),
        .rd_pins   (rd_pins)
    );

    hr_reg_bank #(
        .ADDR_W (ADDR_W),
        .COEF_W (COEF_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_commit),
        .wr_widx     (cap_addr[ADDR_W-1:2]),
        .wr_word     (wr_word),
        .wr_be       (wr_be),
        .rd_widx     (addr[ADDR_W-1:2]),
        .sw_status   (switch_status),
        .mt_status   (match_status),
        .resync_done (resync_done),
        .rd_word     (rd_word),
        .ctrl_q      (ctrl_cfg),
        .match_q     (match_cfg),
        .delay_q     (delay_cfg),
        .coef_flat   (coef_flat),
        .resync_req  (resync_req)
    );

    // drive the pads only during a selected read
    assign data_oe  = !cs_n && !rd_n;
    assign data_out = data_oe ? rd_pins : '0;

    // R5: the bus is released outside a selected read
    p_bus_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!data_oe && data_out == '0));

    // R3: a byte-wide write touches exactly one lane
    p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && bw == BW_8) |-> ($countones(wr_be) == 1));

    // R2: a halfword write touches one aligned lane pair
    p_half_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && bw == BW_16) |-> (wr_be == 4'b0011 || wr_be == 4'b1100));

    // R1: a full-width write enables all lanes
    p_full_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && bw == BW_32) |-> (wr_be == 4'b1111));

endmodule

// File: tb/tb_host_regif.sv
module tb_host_regif;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   bus_width_sel;
    logic         cs_n, rd_n, wr_n;
    logic [7:0]   addr;
    logic [31:0]  data_in;
    logic [31:0]  data_out;
    logic         data_oe;
    logic [31:0]  switch_status, match_status;
    logic         resync_done;
    logic         resync_req;
    logic [7:0]   ctrl_cfg;
    logic [23:0]  match_cfg, delay_cfg;
    logic [767:0] coef_flat;

    int n_chk  = 0;
    int n_fail = 0;

    // bench register model
    logic [7:0]  m_ctrl;
    logic [23:0] m_match, m_delay;
    logic [23:0] m_coef [32];

    always #5 clk = ~clk;

    host_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_width_sel(bus_width_sel),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .switch_status(switch_status), .match_status(match_status),
        .resync_done(resync_done), .resync_req(resync_req),
        .ctrl_cfg(ctrl_cfg), .match_cfg(match_cfg), .delay_cfg(delay_cfg),
        .coef_flat(coef_flat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] bw, input logic [7:0] a);
        if (bw[1])      return 4'hF;
        else if (bw[0]) return a[1] ? 4'hC : 4'h3;
        else            return 4'h1 << a[1:0];
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] bw, input logic [31:0] d);
        if (bw[1])      return d;
        else if (bw[0]) return {d[15:0], d[15:0]};
        else            return {4{d[7:0]}};
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        if (a[7]) return {8'h0, m_coef[a[6:2]]};
        case (a[7:2])
            6'd0:    return {24'h0, m_ctrl};
            6'd1:    return switch_status;
            6'd2:    return {8'h0, m_match};
            6'd3:    return match_status;
            6'd4:    return {8'h0, m_delay};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_pins(input logic [1:0] bw, input logic [7:0] a, input logic [31:0] w);
        if (bw[1])      return w;
        else if (bw[0]) return {16'h0, a[1] ? w[31:16] : w[15:0]};
        else            return {24'h0, w[a[1:0]*8 +: 8]};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic model_write(input logic [1:0] bw, input logic [7:0] a, input logic [31:0] d);
        logic [3:0]  be = exp_be(bw, a);
        logic [31:0] wd = exp_wd(bw, d);
        logic [31:0] mg = merge(exp_word(a), wd, be);
        if (a[7]) m_coef[a[6:2]] = mg[23:0];
        else case (a[7:2])
            6'd0: if (be[0]) begin
                m_ctrl[7:1] = wd[7:1];
                if (!wd[0]) begin
                    m_ctrl[0] = 1'b0;
                    for (int i = 0; i < 32; i++) m_coef[i] = '0;
                end
            end
            6'd2: m_match = mg[23:0] & 24'h0FFFFF;
            6'd4: m_delay = mg[23:0] & 24'h1F7F7F;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [1:0] bw, input logic [7:0] a, input logic [31:0] d, input bit sel);
        @(negedge clk);
        bus_width_sel = bw; addr = a; data_in = d; cs_n = !sel; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        if (sel) model_write(bw, a, d);
    endtask

    task automatic do_read(input logic [1:0] bw, input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_width_sel = bw; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        v = data_out;
        chk("R5 oe during read", {31'h0, data_oe}, 32'h1);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] bw, input logic [7:0] a);
        logic [31:0] v;
        do_read(bw, a, v);
        chk(tag, v, exp_pins(bw, a, exp_word(a)));
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0;
        data_in = '0; bus_width_sel = 2'b10; resync_done = 1'b0;
        switch_status = 32'h8765_4321; match_status = 32'hFEDC_BA98;
        m_ctrl = 8'h8B; m_match = 24'h076543; m_delay = 24'h152B6B;
        for (int i = 0; i < 32; i++) m_coef[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R5 idle oe", {31'h0, data_oe}, 32'h0);
        chk("R5 idle data", data_out, 32'h0);
        chk("R6 reset ctrl", {24'h0, ctrl_cfg}, 32'h8B);
        chk("R8 reset match", {8'h0, match_cfg}, 32'h076543);
        chk("R8 reset delay", {8'h0, delay_cfg}, 32'h152B6B);
        rd_chk("R6 read ctrl", 2'b10, 8'h00);
        rd_chk("R8 read match", 2'b11, 8'h08);
        rd_chk("R8 read delay", 2'b10, 8'h10);
        rd_chk("R7 reset coef", 2'b10, 8'hFC);
        rd_chk("R9 read switch status", 2'b10, 8'h04);
        rd_chk("R9 read match status", 2'b10, 8'h0C);

        // R1: addr low bits ignored in full width
        do_write(2'b10, 8'h83, 32'hA1B2C3D4, 1'b1);
        rd_chk("R1 full word low bits ignored", 2'b10, 8'h81);
        chk("R1 stored coef", {8'h0, m_coef[0]}, 32'h00B2C3D4);

        // R2: halfword lanes
        do_write(2'b01, 8'h86, 32'hFFFF_1357, 1'b1);
        rd_chk("R2 high half", 2'b01, 8'h87);
        rd_chk("R2 low half", 2'b01, 8'h84);
        rd_chk("R4 halfword kept low", 2'b10, 8'h84);

        // R3 / R4: byte lanes
        do_write(2'b00, 8'h89, 32'hFFFF_FF5A, 1'b1);
        rd_chk("R3 byte 1", 2'b00, 8'h89);
        rd_chk("R4 byte write others", 2'b10, 8'h88);

        // R8 reserved bits
        do_write(2'b10, 8'h08, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R8 match reserved", 2'b10, 8'h08);
        do_write(2'b10, 8'h10, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R8 delay reserved", 2'b10, 8'h10);

        // R9 / R10 writes ignored
        do_write(2'b10, 8'h04, 32'h0, 1'b1);
        rd_chk("R9 status write ignored", 2'b10, 8'h04);
        do_write(2'b10, 8'h40, 32'hDEAD_BEEF, 1'b1);
        rd_chk("R10 unmapped zero", 2'b10, 8'h40);
        rd_chk("R10 unmapped 14h", 2'b10, 8'h14);

        // R5 write without chip select ignored
        do_write(2'b10, 8'h90, 32'h0012_3456, 1'b0);
        rd_chk("R5 no select ignored", 2'b10, 8'h90);
        @(negedge clk); rd_n = 1'b0; cs_n = 1'b1; #1;
        chk("R5 rd without cs", {31'h0, data_oe}, 32'h0);
        chk("R5 rd without cs data", data_out, 32'h0);
        rd_n = 1'b1;

        // R6 / R7 soft reset sequence
        do_write(2'b00, 8'h00, 32'h0000_00C0, 1'b1);
        chk("R6 request raised", {31'h0, resync_req}, 32'h1);
        rd_chk("R6 bit0 reads 0", 2'b00, 8'h00);
        chk("R7 coef cleared", {31'h0, coef_flat == '0}, 32'h1);
        rd_chk("R7 match kept", 2'b10, 8'h08);
        rd_chk("R7 delay kept", 2'b10, 8'h10);
        repeat (5) @(negedge clk);
        chk("R6 still pending", {31'h0, resync_req}, 32'h1);
        resync_done = 1'b1; @(negedge clk); resync_done = 1'b0;
        m_ctrl[0] = 1'b1;
        chk("R6 request dropped", {31'h0, resync_req}, 32'h0);
        rd_chk("R6 bit0 back to 1", 2'b10, 8'h00);
        do_write(2'b10, 8'h00, 32'h0000_008B, 1'b1);
        chk("R6 writing 1 no effect", {31'h0, resync_req}, 32'h0);

        // random traffic
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  bw = 2'($urandom_range(0, 3));
            logic [7:0]  a  = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(128, 255))
                                                        : 8'($urandom_range(0, 31));
            logic [31:0] d  = $urandom;
            if (a[7:2] == 6'd0) d[0] = 1'b1;
            switch_status = $urandom; match_status = $urandom;
            do_write(bw, a, d, 1'b1);
            rd_chk("R4 random readback", bw, a);
            rd_chk("R1 random other read", 2'($urandom_range(0, 3)), 8'($urandom));
        end

        // R11 datapath view
        chk("R11 ctrl out", {24'h0, ctrl_cfg}, {24'h0, m_ctrl});
        chk("R11 match out", {8'h0, match_cfg}, {8'h0, m_match});
        chk("R11 delay out", {8'h0, delay_cfg}, {8'h0, m_delay});
        for (int i = 0; i < 32; i++)
            chk("R11 coef out", {8'h0, coef_flat[i*24 +: 24]}, {8'h0, m_coef[i]});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule